// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

The block holds two up-counting timer channels. Each channel has a high count byte, a low count byte, a run bit and a sticky overflow flag. Every channel advances on an internal machine-cycle tick, which is produced by dividing the host clock by a fixed ratio (twelve by default). One shared 8-bit mode register sets the counting mode of both channels. The modes are a 13-bit counter with a prescaler, a cascaded 16-bit counter, an 8-bit counter that reloads from the high byte, and a split mode. In split mode channel 0 becomes two independent 8-bit timers.

Software reaches the block through a single write port. The port selects one of six registers: the mode register, one of the four count bytes, or a control register that sets both run bits and clears the flags. The whole state is visible on output ports, so a host can poll the flags and read the count values.

Top module: `dual_mode_timer`

## Requirements
- R1: While reset is asserted, and directly after it, the mode register, all four count bytes, both run bits and both flags read zero.
- R2: The machine tick fires on the CYC_DIV-th rising edge after reset is released (12 by default), then on every CYC_DIV-th edge after that. Counts change only on tick edges, except when software writes them.
- R3: Mode register bits [1:0] select the mode of channel 0 and bits [5:4] select the mode of channel 1. Codes: 00 = 13-bit, 01 = 16-bit, 10 = 8-bit reload, 11 = split.
- R4: In mode 00, the low five bits of the low byte form a prescaler and the high byte counts each prescaler wrap. Low-byte bits [7:5] hold their value. When the 13-bit value wraps from all-ones to zero, the flag is set.
- R5: In mode 01, {high,low} counts as one 16-bit value. When it wraps from FFFF to 0000, the flag is set and counting continues from 0000 with no reload.
- R6: In mode 10, the low byte counts. When it wraps from FF, it loads the high byte instead and the flag is set. The high byte does not change.
- R7: When channel 0 is in mode 11, its low byte is an 8-bit timer gated by run bit 0 that sets flag 0. Its high byte is an 8-bit timer gated by run bit 1 that sets flag 1.
- R8: While channel 0 is in split mode, channel 1 counts in its own mode whatever run bit 1 holds, and its wraps never set flag 1. A channel 1 that is itself in mode 11 holds its count.
- R9: A channel whose run bit is clear holds its count.
- R10: A flag stays set until a control write clears it (bit 4 clears flag 0, bit 5 clears flag 1). An overflow in the same cycle as a clear leaves the flag set.
- R11: Write select codes: 0 mode, 1 ch0 low, 2 ch0 high, 3 ch1 low, 4 ch1 high, 5 control (bit0 = run 0, bit1 = run 1). A count-byte write in a tick cycle stores the written value. The other select codes change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | SEL_W | Register select code |
| wr_data_i | input | 8 | Write data |
| mode_o | output | 8 | Mode register contents |
| c0_lo_o | output | 8 | Channel 0 low count byte |
| c0_hi_o | output | 8 | Channel 0 high count byte |
| c1_lo_o | output | 8 | Channel 1 low count byte |
| c1_hi_o | output | 8 | Channel 1 high count byte |
| run_o | output | 2 | Run bits, bit g for channel g |
| flag_o | output | 2 | Overflow flags, bit g for channel g |

## Verification
The hardest case to reach is a flag clear that lands on exactly the rising edge where a wrap sets the same flag. A count-byte write on a tick edge is just as hard to hit. The tick is internal, so the bench keeps its own phase counter from the reset release. It waits for the phase just after a tick, starts the channel, and counts edges so that the clearing or loading write falls on the next tick edge. The borrowed run bit in split mode is hard for the same reason: channel 1 runs freely from the moment the mode is written. The mode write is therefore also aligned to that phase.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int BYTE_W = 8;
   localparam int N_CH   = 2;

   typedef enum logic [1:0] {
      MD_PRE13 = 2'b00,
      MD_CAS16 = 2'b01,
      MD_RELD8 = 2'b10,
      MD_SPLIT = 2'b11
   } tmr_mode_e;

   // write select codes; ch g low byte = 1+2g, high byte = 2+2g
   localparam int RS_MODE = 0;
   localparam int RS_CTRL = 5;

   // control byte fields
   localparam int CTL_RUN0 = 0;
   localparam int CTL_CLR0 = 4;
endpackage

// File: rtl/tmr_tick_div.sv
module tmr_tick_div #(
   parameter int DIV = 12
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   generate
      if (DIV < 2) begin : g_bad_div
         $error("tmr_tick_div: DIV must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (cnt_q == LAST)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/tmr_count_unit.sv
module tmr_count_unit
   import tmr_pkg::*;
#(
   parameter int PRE_W = 5
) (
   input  tmr_mode_e          mode_i,
   input  logic               step_lo_i,
   input  logic               step_hi_i,
   input  logic [BYTE_W-1:0]  lo_i,
   input  logic [BYTE_W-1:0]  hi_i,
   output logic [BYTE_W-1:0]  lo_o,
   output logic [BYTE_W-1:0]  hi_o,
   output logic               wrap_lo_o,
   output logic               wrap_hi_o
);
   localparam int W_PRE = BYTE_W + PRE_W;
   localparam int W_CAS = 2 * BYTE_W;

   generate
      if (PRE_W < 1 || PRE_W > BYTE_W) begin : g_bad_pre
         $error("tmr_count_unit: PRE_W must lie in 1..BYTE_W");
      end
   endgenerate

   logic [W_PRE-1:0] pre_cat, pre_sum;
   logic [W_CAS-1:0] cas_cat, cas_sum;

   assign pre_cat = {hi_i, lo_i[PRE_W-1:0]};
   assign pre_sum = pre_cat + 1'b1;
   assign cas_cat = {hi_i, lo_i};
   assign cas_sum = cas_cat + 1'b1;

   always_comb begin
      lo_o      = lo_i;
      hi_o      = hi_i;
      wrap_lo_o = 1'b0;
      wrap_hi_o = 1'b0;
      unique case (mode_i)
         MD_PRE13: if (step_lo_i) begin
            lo_o[PRE_W-1:0] = pre_sum[PRE_W-1:0];
            hi_o            = pre_sum[W_PRE-1:PRE_W];
            wrap_lo_o       = &pre_cat;
         end
         MD_CAS16: if (step_lo_i) begin
            {hi_o, lo_o} = cas_sum;
            wrap_lo_o    = &cas_cat;
         end
         MD_RELD8: if (step_lo_i) begin
            lo_o      = (&lo_i) ? hi_i : lo_i + 1'b1;
            wrap_lo_o = &lo_i;
         end
         MD_SPLIT: begin
            if (step_lo_i) begin
               lo_o      = lo_i + 1'b1;
               wrap_lo_o = &lo_i;
            end
            if (step_hi_i) begin
               hi_o      = hi_i + 1'b1;
               wrap_hi_o = &hi_i;
            end
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/tmr_flag_bank.sv
module tmr_flag_bank #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o
);
   generate
      for (genvar g = 0; g < N; g++) begin : g_flag
         logic q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= 1'b0;
            else
               q <= set_i[g] | (q & ~clr_i[g]);
         end
         assign flag_o[g] = q;
      end
   endgenerate
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
   import tmr_pkg::*;
#(
   parameter int CYC_DIV = 12,
   parameter int PRE_W   = 5,
   parameter int SEL_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [SEL_W-1:0] wr_sel_i,
   input  logic [7:0]       wr_data_i,
   output logic [7:0]       mode_o,
   output logic [7:0]       c0_lo_o,
   output logic [7:0]       c0_hi_o,
   output logic [7:0]       c1_lo_o,
   output logic [7:0]       c1_hi_o,
   output logic [1:0]       run_o,
   output logic [1:0]       flag_o
);
   localparam int NIB = BYTE_W / 2;

   generate
      if (SEL_W < 3) begin : g_bad_sel
         $error("dual_mode_timer: SEL_W must be at least 3");
      end
   endgenerate

   logic                tick;
   logic [BYTE_W-1:0]   mode_q;
   logic [N_CH-1:0]     run_q;
   logic                ctrl_wr;
   logic                split;
   logic [N_CH-1:0]     wrap_lo, wrap_hi, flag_set, flag_clr;
   logic [BYTE_W-1:0]   cnt_lo [N_CH];
   logic [BYTE_W-1:0]   cnt_hi [N_CH];
   tmr_mode_e           ch_mode [N_CH];

   tmr_tick_div #(.DIV(CYC_DIV)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   assign ctrl_wr = wr_en_i && (wr_sel_i == SEL_W'(RS_CTRL));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
         run_q  <= '0;
      end else begin
         if (wr_en_i && (wr_sel_i == SEL_W'(RS_MODE)))
            mode_q <= wr_data_i;
         if (ctrl_wr)
            run_q <= wr_data_i[CTL_RUN0 +: N_CH];
      end
   end

   assign split = (ch_mode[0] == MD_SPLIT);

   generate
      for (genvar g = 0; g < N_CH; g++) begin : g_ch
         logic [BYTE_W-1:0] lo_q, hi_q, lo_n, hi_n;
         logic              step_lo, step_hi, wr_lo, wr_hi;

         assign ch_mode[g] = tmr_mode_e'(mode_q[NIB*g +: 2]);
         assign wr_lo = wr_en_i && (wr_sel_i == SEL_W'(1 + 2*g));
         assign wr_hi = wr_en_i && (wr_sel_i == SEL_W'(2 + 2*g));

         if (g == 0) begin : g_first
            assign step_lo = tick & run_q[0];
            assign step_hi = tick & run_q[1] & split;
         end else begin : g_other
            assign step_lo = tick & (split | run_q[g]) & (ch_mode[g] != MD_SPLIT);
            assign step_hi = 1'b0;
         end

         tmr_count_unit #(.PRE_W(PRE_W)) u_cnt (
            .mode_i    (ch_mode[g]),
            .step_lo_i (step_lo),
            .step_hi_i (step_hi),
            .lo_i      (lo_q),
            .hi_i      (hi_q),
            .lo_o      (lo_n),
            .hi_o      (hi_n),
            .wrap_lo_o (wrap_lo[g]),
            .wrap_hi_o (wrap_hi[g])
         );

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               lo_q <= '0;
               hi_q <= '0;
            end else begin
               lo_q <= wr_lo ? wr_data_i : lo_n;
               hi_q <= wr_hi ? wr_data_i : hi_n;
            end
         end

         assign cnt_lo[g]   = lo_q;
         assign cnt_hi[g]   = hi_q;
         assign flag_clr[g] = ctrl_wr & wr_data_i[CTL_CLR0 + g];
      end
   endgenerate

   // channel 0 high byte borrows flag 1 while split
   assign flag_set[0] = wrap_lo[0];
   assign flag_set[1] = split ? wrap_hi[0] : (wrap_lo[1] | wrap_hi[1]);

   tmr_flag_bank #(.N(N_CH)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (flag_set),
      .clr_i  (flag_clr),
      .flag_o (flag_o)
   );

   assign mode_o  = mode_q;
   assign run_o   = run_q;
   assign c0_lo_o = cnt_lo[0];
   assign c0_hi_o = cnt_hi[0];
   assign c1_lo_o = cnt_lo[1];
   assign c1_hi_o = cnt_hi[1];
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
   parameter int SEL_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             wr_en,
   input logic [SEL_W-1:0] wr_sel,
   input logic             clr0_bit,
   input logic [1:0]       mode0,
   input logic [7:0]       c0_lo,
   input logic [7:0]       c0_hi,
   input logic             run0,
   input logic             flag0
);
   logic wr_c0;
   logic clr0_wr;
   assign wr_c0   = wr_en && (wr_sel == SEL_W'(1) || wr_sel == SEL_W'(2));
   assign clr0_wr = wr_en && (wr_sel == SEL_W'(5)) && clr0_bit;

   p_reset_zero_r1: assert property (@(posedge clk)
      !rst_n |=> (c0_lo == 8'h00 && c0_hi == 8'h00 && !run0 && !flag0 && mode0 == 2'b00));

   p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   p_no_step_off_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr_c0) |=> $stable({c0_hi, c0_lo}));

   p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode0 == 2'b10 && tick && run0 && c0_lo == 8'hFF && !wr_c0)
      |=> c0_lo == $past(c0_hi));

   p_hold_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!run0 && mode0 != 2'b11 && !wr_c0) |=> $stable({c0_hi, c0_lo}));

   p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag0 && !clr0_wr) |=> flag0);

   p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode0 == 2'b10 && tick && run0 && c0_lo == 8'hFF) |=> flag0);
endmodule

bind dual_mode_timer tmr_checker #(.SEL_W(SEL_W)) u_tmr_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .wr_en    (wr_en_i),
   .wr_sel   (wr_sel_i),
   .clr0_bit (wr_data_i[4]),
   .mode0    (mode_o[1:0]),
   .c0_lo    (c0_lo_o),
   .c0_hi    (c0_hi_o),
   .run0     (run_o[0]),
   .flag0    (flag_o[0])
);

// File: tb/dual_mode_timer_tb_top.sv
`timescale 1ns/100ps
module dual_mode_timer_tb_top;
   localparam int TK = 12;
   localparam int WD_CYC = 200000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_sel = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] mode, c0_lo, c0_hi, c1_lo, c1_hi;
   logic [1:0] run, flag;

   int n_run = 0, n_fail = 0, bph = 0;
   bit done = 0;

   typedef struct { string req; int w; logic [7:0] exp; } item_t;
   item_t sbq[$];

   always #2.5 clk = ~clk;

   dual_mode_timer dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
      .wr_data_i(wr_data), .mode_o(mode), .c0_lo_o(c0_lo), .c0_hi_o(c0_hi),
      .c1_lo_o(c1_lo), .c1_hi_o(c1_hi), .run_o(run), .flag_o(flag)
   );

   // bench copy of the tick phase, from R2
   always @(posedge clk) begin
      if (!rst_n) bph <= 0;
      else bph <= (bph == TK-1) ? 0 : bph + 1;
   end

   function automatic logic [7:0] rd(int w);
      case (w)
         0: return c0_lo;
         1: return c0_hi;
         2: return c1_lo;
         3: return c1_hi;
         4: return mode;
         5: return {6'd0, run};
         default: return {6'd0, flag};
      endcase
   endfunction

   // driver side of the scoreboard
   task automatic expect_val(string req, int w, logic [7:0] e);
      item_t it;
      it.req = req; it.w = w; it.exp = e;
      sbq.push_back(it);
   endtask

   // monitor side
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            n_run++;
            if (rd(it.w) !== it.exp) begin
               n_fail++;
               $display("FAIL %s: output %0d got %02h expected %02h", it.req, it.w, rd(it.w), it.exp);
            end
         end
      end
   end

   task automatic wr(int sel, logic [7:0] d);
      wr_en = 1'b1; wr_sel = 3'(sel); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic align();
      while (bph != 0) @(negedge clk);
   endtask

   // start with ctrl, let n ticks pass, stop on a non-tick edge
   task automatic run_for(logic [7:0] ctrl, int n);
      align();
      wr(5, ctrl);
      repeat (TK*n - 1) @(negedge clk);
      wr(5, 8'h00);
   endtask

   initial begin
      #(WD_CYC * 5.0);
      if (!done) begin
         n_fail++;
         $display("FAIL R2: watchdog got hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      expect_val("R1 c0_lo", 0, 8'h00); expect_val("R1 c1_hi", 3, 8'h00);
      expect_val("R1 mode", 4, 8'h00);  expect_val("R1 run", 5, 8'h00);
      expect_val("R1 flag", 6, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 / R11 mode write
      wr(0, 8'h21);
      expect_val("R3 mode readback", 4, 8'h21);

      // R6 reload
      wr(0, 8'h02); wr(2, 8'hFD); wr(1, 8'hFD);
      run_for(8'h01, 3);
      expect_val("R6 reload low", 0, 8'hFD);
      expect_val("R6 high unchanged", 1, 8'hFD);
      expect_val("R6 flag", 6, 8'h01);
      expect_val("R9 run cleared", 5, 8'h00);

      // R10 sticky then cleared
      repeat (20) @(negedge clk);
      expect_val("R10 flag sticky", 6, 8'h01);
      wr(5, 8'h10);
      expect_val("R10 flag cleared", 6, 8'h00);

      // R2 tick spacing
      wr(0, 8'h01); wr(1, 8'h34); wr(2, 8'h12);
      align();
      wr(5, 8'h01);
      repeat (10) @(negedge clk);
      expect_val("R2 no step before tick", 0, 8'h34);
      @(negedge clk);
      expect_val("R2 step on tick", 0, 8'h35);
      wr(5, 8'h00);

      // R5 16-bit wrap, no reload
      wr(1, 8'hFE); wr(2, 8'hFF);
      run_for(8'h01, 3);
      expect_val("R5 low", 0, 8'h01);
      expect_val("R5 high", 1, 8'h00);
      expect_val("R5 flag", 6, 8'h01);
      wr(5, 8'h10);

      // R4 13-bit prescaled
      wr(0, 8'h00); wr(2, 8'h05); wr(1, 8'hFE);
      run_for(8'h01, 3);
      expect_val("R4 low keeps top bits", 0, 8'hE1);
      expect_val("R4 high carry", 1, 8'h06);
      expect_val("R4 no flag", 6, 8'h00);
      wr(2, 8'hFF); wr(1, 8'h1F);
      run_for(8'h01, 1);
      expect_val("R4 wrap low", 0, 8'h00);
      expect_val("R4 wrap high", 1, 8'h00);
      expect_val("R4 wrap flag", 6, 8'h01);
      wr(5, 8'h10);

      // R9 hold when stopped
      wr(0, 8'h01); wr(1, 8'h40); wr(2, 8'h00);
      repeat (30) @(negedge clk);
      expect_val("R9 hold low", 0, 8'h40);
      expect_val("R9 hold high", 1, 8'h00);

      // R7 split
      wr(0, 8'h03); wr(1, 8'hFE); wr(2, 8'h10);
      run_for(8'h03, 2);
      expect_val("R7 split low", 0, 8'h00);
      expect_val("R7 split high", 1, 8'h12);
      expect_val("R7 flag0 only", 6, 8'h01);
      wr(5, 8'h30);
      wr(2, 8'hFF);
      run_for(8'h02, 1);
      expect_val("R7 high wrap", 1, 8'h00);
      expect_val("R7 low held", 0, 8'h00);
      expect_val("R7 flag1 only", 6, 8'h02);
      wr(0, 8'h00);
      wr(5, 8'h30);

      // R8 channel 1 while channel 0 split
      wr(0, 8'h10); wr(3, 8'hFE); wr(4, 8'hFF);
      align();
      wr(0, 8'h13);
      wr(5, 8'h01);
      repeat (TK*3 - 2) @(negedge clk);
      wr(5, 8'h00);
      expect_val("R8 ch1 free low", 2, 8'h01);
      expect_val("R8 ch1 free high", 3, 8'h00);
      expect_val("R8 no flag1", 6, 8'h00);
      wr(0, 8'h30);
      run_for(8'h02, 2);
      expect_val("R8 ch1 split holds", 2, 8'h01);
      expect_val("R3 nibble select", 3, 8'h00);

      // R10 set beats clear
      wr(0, 8'h02); wr(2, 8'h80); wr(1, 8'hFF);
      align();
      wr(5, 8'h01);
      repeat (10) @(negedge clk);
      wr(5, 8'h11);
      wr(5, 8'h00);
      expect_val("R10 set beats clear", 6, 8'h01);
      expect_val("R6 reload at clear", 0, 8'h80);
      wr(5, 8'h10);
      expect_val("R10 later clear", 6, 8'h00);

      // R11 write on tick edge wins
      wr(0, 8'h10); wr(3, 8'h20); wr(4, 8'h00);
      align();
      wr(5, 8'h02);
      repeat (10) @(negedge clk);
      wr(3, 8'h55);
      wr(5, 8'h00);
      expect_val("R11 write wins tick", 2, 8'h55);

      // R11 unused select codes
      wr(7, 8'hFF); wr(6, 8'hFF);
      expect_val("R11 unused mode", 4, 8'h10);
      expect_val("R11 unused run", 5, 8'h00);
      expect_val("R11 unused flag", 6, 8'h00);
      expect_val("R11 unused c1", 2, 8'h55);
      expect_val("R11 unused c0", 0, 8'h80);

      repeat (3) @(negedge clk);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule